// File: doc/BRIEF.md
# Keypad Code Lock Controller

This block is the decision core of a keypad-operated door lock. It receives already-decoded key events (one pulse per key, with a 4-bit code) and tracks what the user is typing. A user first types an identity number and confirms it, then types a password and confirms it. When both match the stored values, the block runs a door cycle. The actuator is driven in the opening direction for a fixed number of cycles. The door is then held unlatched for a preset time. Finally the actuator is driven the other way so the door latches again without anyone acting on it.

Wrong attempts are counted. After a set number of consecutive misses the controller refuses ordinary entries until a longer administrator code is typed in full. A user who has just proved the current code may replace the password. Every key that the controller takes produces a short buzzer pulse. The three stored codes sit in registers that a host writes through a parallel load port. Persistent storage, actuator phase sequencing and keypad scanning are handled elsewhere.

Top module: `lock_ctrl_top`

## Requirements
- R1: Key codes 0 to 9 are digits, 10 is confirm, 11 is clear and 12 is change. A key is taken when key_valid is high, key_code is 12 or less and no door cycle is running. Each key taken raises beep for BEEP_CYC cycles, starting in the cycle after the key. Codes 13 to 15, and any key during a door cycle, cause no beep and have no effect.
- R2: Typing ID_LEN identity digits, confirm, PW_LEN password digits and confirm starts a door cycle when both entries have the right length and value. The first digit typed must equal the most significant nibble of the stored code. motor_fwd is then high for DRIVE_CYC cycles, starting in the cycle after the final confirm.
- R3: When the forward drive ends, lock_open is high for HOLD_CYC cycles. motor_rev is then high for DRIVE_CYC cycles, after which the block is idle. At most one of motor_fwd, motor_rev and lock_open is high in any cycle.
- R4: A password confirm counts one failure and returns to identity entry when the identity or the password was wrong in value or length. A wrong identity is only reported at the password confirm.
- R5: After MAX_FAILS consecutive failures, blocked is high. While it is high, identity and password entries open nothing and add no failure.
- R6: At the identity stage, ADM_LEN digits equal to the stored administrator code, followed by confirm, start a door cycle and clear the failure count, which drops blocked. This works whether or not the controller is blocked.
- R7: A correct identity and password clears the failure count, so only consecutive failures lead to blocking.
- R8: The clear key discards the entry in progress and any armed change, returns to identity entry and counts no failure.
- R9: A digit typed while ADM_LEN digits are already held counts as a failure (unless blocked) and returns to identity entry.
- R10: The change key at the identity stage arms a code change. A correct identity and password then open nothing. Instead, the next confirm with exactly PW_LEN digits stores them as the new password, and code_changed_pulse is high for one cycle after that confirm. A new entry of any other length is dropped with no failure.
- R11: cfg_load writes all three stored codes at the next clock edge. After reset, all outputs are low and the failure count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| key_valid | input | 1 | One-cycle key event strobe |
| key_code | input | 4 | Decoded key code |
| cfg_load | input | 1 | Load all stored codes |
| cfg_user_id | input | 4*ID_LEN | Identity code, first digit in the top nibble |
| cfg_user_pw | input | 4*PW_LEN | Password, first digit in the top nibble |
| cfg_admin | input | 4*ADM_LEN | Administrator code, first digit in the top nibble |
| lock_open | output | 1 | Door held unlatched |
| motor_fwd | output | 1 | Actuator driven in the opening direction |
| motor_rev | output | 1 | Actuator driven in the closing direction |
| beep | output | 1 | Buzzer pulse for an accepted key |
| blocked | output | 1 | Lockout after repeated failures |
| code_changed_pulse | output | 1 | Password replaced through the keypad |

## Verification
A failure counter that is off by one shows at blocked on the confirm that should have reached the limit, or fails to show there. It also shows when an ordinary code stays without effect after an administrator recovery. A mis-tracked entry stage or digit buffer shows on motor_fwd in the cycle right after the final confirm, either as a door cycle that should not start or as one that is missing. Timer faults move the motor_fwd, lock_open and motor_rev edges by whole cycles. The reference model compares every output on every clock, so such a fault is reported in the first cycle where it differs.

// File: rtl/lock_pkg.sv
// Shared types and key codes for the keypad code lock controller.
// Assumes key codes arrive already decoded, one per key_valid strobe.
package lock_pkg;

    typedef enum logic [1:0] {
        ST_ID  = 2'd0,   // collecting identity (or administrator) digits
        ST_PW  = 2'd1,   // collecting password digits
        ST_NEW = 2'd2    // collecting a replacement password
    } entry_st_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FWD  = 2'd1,
        PH_HOLD = 2'd2,
        PH_REV  = 2'd3
    } act_ph_t;

    localparam logic [3:0] KEY_LAST_DIGIT = 4'd9;
    localparam logic [3:0] KEY_ENTER      = 4'd10;
    localparam logic [3:0] KEY_CLEAR      = 4'd11;
    localparam logic [3:0] KEY_CHANGE     = 4'd12;

endpackage

// File: rtl/lock_digit_buf.sv
// Digit entry buffer: shifts decimal digits in at the low nibble and counts them.
// Assumes the caller clears it before it would exceed MAX_DIGITS (full flags that point).
module lock_digit_buf #(
    parameter int MAX_DIGITS = 10,
    localparam int LW = $clog2(MAX_DIGITS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    push,
    input  logic [3:0]              digit,
    output logic [4*MAX_DIGITS-1:0] digits,
    output logic [LW-1:0]           count,
    output logic                    full
);

    // Shift register plus occupancy counter; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            digits <= '0;
            count  <= '0;
        end else if (push && !full) begin
            digits <= {digits[4*MAX_DIGITS-5:0], digit};
            count  <= count + LW'(1);
        end
    end

    // Buffer holds the maximum number of digits.
    assign full = (count == LW'(MAX_DIGITS));

endmodule

// File: rtl/lock_actuator_seq.sv
// Door actuator sequencer: forward drive, hold open, reverse drive, each timed.
// Assumes start is only raised while busy is low; phases never overlap.
module lock_actuator_seq
    import lock_pkg::*;
#(
    parameter int DRIVE_CYC = 8,
    parameter int HOLD_CYC  = 20,
    localparam int MAXC = (DRIVE_CYC > HOLD_CYC) ? DRIVE_CYC : HOLD_CYC,
    localparam int TW   = $clog2(MAXC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic motor_fwd,
    output logic motor_rev,
    output logic lock_open,
    output logic busy
);

    act_ph_t       ph_q;
    logic [TW-1:0] tmr_q;

    // Phase register with a down-counting dwell timer per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_IDLE;
            tmr_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (start) begin
                    ph_q  <= PH_FWD;
                    tmr_q <= TW'(DRIVE_CYC - 1);
                end
                PH_FWD: if (tmr_q == '0) begin
                    ph_q  <= PH_HOLD;
                    tmr_q <= TW'(HOLD_CYC - 1);
                end else tmr_q <= tmr_q - TW'(1);
                PH_HOLD: if (tmr_q == '0) begin
                    ph_q  <= PH_REV;
                    tmr_q <= TW'(DRIVE_CYC - 1);
                end else tmr_q <= tmr_q - TW'(1);
                default: if (tmr_q == '0) ph_q <= PH_IDLE;
                         else tmr_q <= tmr_q - TW'(1);
            endcase
        end
    end

    // Decode one output per phase.
    assign motor_fwd = (ph_q == PH_FWD);
    assign lock_open = (ph_q == PH_HOLD);
    assign motor_rev = (ph_q == PH_REV);
    assign busy      = (ph_q != PH_IDLE);

endmodule

// File: rtl/lock_beep_gen.sv
// Key acknowledge buzzer: a retriggerable pulse of BEEP_CYC cycles.
// Assumes trig is a single-cycle event per accepted key.
module lock_beep_gen #(
    parameter int BEEP_CYC = 4,
    localparam int BW = $clog2(BEEP_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic beep
);

    logic [BW-1:0] cnt_q;

    // Reload on each trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (trig)         cnt_q <= BW'(BEEP_CYC);
        else if (cnt_q != '0)  cnt_q <= cnt_q - BW'(1);
    end

    assign beep = (cnt_q != '0);

endmodule

// File: rtl/lock_ctrl_top.sv
// Keypad code lock controller: checks identity and password, runs the door
// cycle, counts consecutive failures into a lockout, accepts an administrator
// override and lets a verified user replace the password.
// Assumes ADM_LEN differs from ID_LEN and is the longest code.
module lock_ctrl_top
    import lock_pkg::*;
#(
    parameter int ID_LEN    = 4,
    parameter int PW_LEN    = 4,
    parameter int ADM_LEN   = 10,
    parameter int MAX_FAILS = 3,
    parameter int DRIVE_CYC = 8,
    parameter int HOLD_CYC  = 20,
    parameter int BEEP_CYC  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 key_valid,
    input  logic [3:0]           key_code,
    input  logic                 cfg_load,
    input  logic [4*ID_LEN-1:0]  cfg_user_id,
    input  logic [4*PW_LEN-1:0]  cfg_user_pw,
    input  logic [4*ADM_LEN-1:0] cfg_admin,
    output logic                 lock_open,
    output logic                 motor_fwd,
    output logic                 motor_rev,
    output logic                 beep,
    output logic                 blocked,
    output logic                 code_changed_pulse
);

    localparam int LW = $clog2(ADM_LEN + 1);
    localparam int FW = $clog2(MAX_FAILS + 1);

    entry_st_t            st_q, st_d;
    logic                 chg_q, chg_d, id_ok_q, id_ok_d;
    logic [FW-1:0]        fail_q;
    logic [4*ID_LEN-1:0]  id_q;
    logic [4*PW_LEN-1:0]  pw_q;
    logic [4*ADM_LEN-1:0] adm_q;
    logic [4*ADM_LEN-1:0] buf_digits;
    logic [LW-1:0]        buf_cnt;
    logic                 buf_full, buf_clr, door_busy, grant;
    logic                 fail_inc, fail_clr, pw_we, chg_pulse_q;

    // Key classification; keys are refused while the door cycle runs.
    wire key_acc  = key_valid && (key_code <= KEY_CHANGE) && !door_busy;
    wire is_digit = (key_code <= KEY_LAST_DIGIT);
    wire id_match  = (buf_cnt == LW'(ID_LEN))  && (buf_digits[4*ID_LEN-1:0] == id_q);
    wire pw_match  = (buf_cnt == LW'(PW_LEN))  && (buf_digits[4*PW_LEN-1:0] == pw_q);
    wire adm_match = (buf_cnt == LW'(ADM_LEN)) && (buf_digits == adm_q);
    wire blk_w     = (fail_q == FW'(MAX_FAILS));

    lock_digit_buf #(.MAX_DIGITS(ADM_LEN)) buf_i (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr),
        .push(key_acc && is_digit), .digit(key_code),
        .digits(buf_digits), .count(buf_cnt), .full(buf_full)
    );

    lock_actuator_seq #(.DRIVE_CYC(DRIVE_CYC), .HOLD_CYC(HOLD_CYC)) act_i (
        .clk(clk), .rst_n(rst_n), .start(grant),
        .motor_fwd(motor_fwd), .motor_rev(motor_rev),
        .lock_open(lock_open), .busy(door_busy)
    );

    lock_beep_gen #(.BEEP_CYC(BEEP_CYC)) beep_i (
        .clk(clk), .rst_n(rst_n), .trig(key_acc), .beep(beep)
    );

    // Entry decision logic: next stage, verdicts and side effects per key.
    always_comb begin
        st_d     = st_q;
        chg_d    = chg_q;
        id_ok_d  = id_ok_q;
        buf_clr  = 1'b0;
        fail_inc = 1'b0;
        fail_clr = 1'b0;
        grant    = 1'b0;
        pw_we    = 1'b0;
        if (key_acc) begin
            if (is_digit && buf_full) begin
                buf_clr  = 1'b1;
                st_d     = ST_ID;
                chg_d    = 1'b0;
                fail_inc = (st_q != ST_NEW) && !blk_w;
            end else if (key_code == KEY_CLEAR) begin
                buf_clr = 1'b1;
                st_d    = ST_ID;
                chg_d   = 1'b0;
            end else if (key_code == KEY_CHANGE) begin
                if (st_q == ST_ID) chg_d = 1'b1;
            end else if (key_code == KEY_ENTER) begin
                buf_clr = 1'b1;
                case (st_q)
                    ST_ID: begin
                        if (adm_match) begin
                            grant    = 1'b1;
                            fail_clr = 1'b1;
                            chg_d    = 1'b0;
                        end else if (blk_w) begin
                            chg_d = 1'b0;
                        end else begin
                            id_ok_d = id_match;
                            st_d    = ST_PW;
                        end
                    end
                    ST_PW: begin
                        st_d  = ST_ID;
                        chg_d = 1'b0;
                        if (id_ok_q && pw_match) begin
                            fail_clr = 1'b1;
                            if (chg_q) st_d = ST_NEW;
                            else       grant = 1'b1;
                        end else begin
                            fail_inc = 1'b1;
                        end
                    end
                    default: begin
                        st_d  = ST_ID;
                        pw_we = (buf_cnt == LW'(PW_LEN));
                    end
                endcase
            end
        end
    end

    // Entry stage, change arm flag and deferred identity verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_ID;
            chg_q   <= 1'b0;
            id_ok_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            chg_q   <= chg_d;
            id_ok_q <= id_ok_d;
        end
    end

    // Consecutive failure counter, saturating at the lockout limit.
    always_ff @(posedge clk) begin
        if (!rst_n || fail_clr)                   fail_q <= '0;
        else if (fail_inc && !blk_w)              fail_q <= fail_q + FW'(1);
    end

    // Stored codes: host load wins over a keypad password change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q  <= '0;
            pw_q  <= '0;
            adm_q <= '0;
        end else if (cfg_load) begin
            id_q  <= cfg_user_id;
            pw_q  <= cfg_user_pw;
            adm_q <= cfg_admin;
        end else if (pw_we) begin
            pw_q  <= buf_digits[4*PW_LEN-1:0];
        end
    end

    // One-cycle acknowledge of a keypad password change.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_pulse_q <= 1'b0;
        else        chg_pulse_q <= pw_we;
    end

    assign blocked            = blk_w;
    assign code_changed_pulse = chg_pulse_q;

endmodule

// File: rtl/lock_ctrl_chk.sv
// Port-level property checker for lock_ctrl_top, attached with bind below.
// Assumes the default key code map (12 is the highest accepted code).
module lock_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       key_valid,
    input logic [3:0] key_code,
    input logic       lock_open,
    input logic       motor_fwd,
    input logic       motor_rev,
    input logic       beep,
    input logic       blocked,
    input logic       code_changed_pulse
);

    AST_DRIVE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(motor_fwd && motor_rev)); // R3

    AST_OPEN_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lock_open |-> (!motor_fwd && !motor_rev)); // R3

    AST_FWD_THEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(motor_fwd) |-> lock_open); // R3

    AST_HOLD_THEN_REV: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_open) |-> motor_rev); // R3

    AST_KEY_BEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && key_code <= 4'd12 && !motor_fwd && !motor_rev && !lock_open)
        |=> beep); // R1

    AST_UNBLOCK_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blocked) |-> motor_fwd); // R6

    AST_CHG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        code_changed_pulse |=> !code_changed_pulse); // R10

endmodule

bind lock_ctrl_top lock_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
    .lock_open(lock_open), .motor_fwd(motor_fwd), .motor_rev(motor_rev),
    .beep(beep), .blocked(blocked), .code_changed_pulse(code_changed_pulse)
);

// File: tb/lock_ctrl_top_tb.sv
// Bench for lock_ctrl_top: behavioural reference model compared every clock,
// plus directed checks at the scenario points the requirements call out.
module lock_ctrl_top_tb_top;

    localparam int DRV = 5, HLD = 12, BP = 3, MAXF = 3, ADM = 10, IDL = 4, PWL = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic key_valid = 1'b0, cfg_load = 1'b0;
    logic [3:0]  key_code = 4'd0;
    logic [15:0] cfg_user_id = 16'h1234, cfg_user_pw = 16'h5678;
    logic [39:0] cfg_admin = 40'h9876543210;
    logic lock_open, motor_fwd, motor_rev, beep, blocked, code_changed_pulse;

    always #10 clk = ~clk;

    lock_ctrl_top #(.DRIVE_CYC(DRV), .HOLD_CYC(HLD), .BEEP_CYC(BP)) dut_i (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
        .cfg_load(cfg_load), .cfg_user_id(cfg_user_id), .cfg_user_pw(cfg_user_pw),
        .cfg_admin(cfg_admin), .lock_open(lock_open), .motor_fwd(motor_fwd),
        .motor_rev(motor_rev), .beep(beep), .blocked(blocked),
        .code_changed_pulse(code_changed_pulse)
    );

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 1'b0, done = 1'b0;

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_stage, m_fails, m_phase, m_tmr, m_beep;
    bit m_chg, m_idok, m_chgp;
    int q[$];
    logic [15:0] m_id, m_pw;
    logic [39:0] m_adm;

    function automatic bit q_is(int n, logic [39:0] ref_code);
        if (q.size() != n) return 1'b0;
        for (int i = 0; i < n; i++)
            if (q[i] != int'(ref_code[4*(n-1-i) +: 4])) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0; m_fails = 0; m_phase = 0; m_tmr = 0; m_beep = 0;
            m_chg = 0; m_idok = 0; m_chgp = 0; q.delete();
            m_id = '0; m_pw = '0; m_adm = '0;
        end else begin
            bit acc, blk, grant;
            int kc;
            kc = int'(key_code);
            acc = key_valid && kc <= 12 && m_phase == 0;
            blk = (m_fails == MAXF);
            grant = 0;
            m_chgp = 0;
            if (m_phase != 0) begin
                if (m_tmr == 0) begin
                    if (m_phase == 1)      begin m_phase = 2; m_tmr = HLD - 1; end
                    else if (m_phase == 2) begin m_phase = 3; m_tmr = DRV - 1; end
                    else m_phase = 0;
                end else m_tmr--;
            end
            if (acc) m_beep = BP; else if (m_beep > 0) m_beep--;
            if (acc) begin
                if (kc <= 9) begin
                    if (q.size() == ADM) begin
                        if (m_stage != 2 && !blk) m_fails++;
                        q.delete(); m_stage = 0; m_chg = 0;
                    end else q.push_back(kc);
                end else if (kc == 11) begin
                    q.delete(); m_stage = 0; m_chg = 0;
                end else if (kc == 12) begin
                    if (m_stage == 0) m_chg = 1;
                end else begin
                    if (m_stage == 0) begin
                        if (q_is(ADM, m_adm)) begin grant = 1; m_fails = 0; m_chg = 0; end
                        else if (blk) m_chg = 0;
                        else begin m_idok = q_is(IDL, {24'd0, m_id}); m_stage = 1; end
                    end else if (m_stage == 1) begin
                        m_stage = 0;
                        if (m_idok && q_is(PWL, {24'd0, m_pw})) begin
                            m_fails = 0;
                            if (m_chg) m_stage = 2; else grant = 1;
                        end else m_fails++;
                        m_chg = 0;
                    end else begin
                        m_stage = 0;
                        if (q.size() == PWL) begin
                            m_pw = 16'(q[0] * 4096 + q[1] * 256 + q[2] * 16 + q[3]);
                            m_chgp = 1;
                        end
                    end
                    q.delete();
                end
            end
            if (grant) begin m_phase = 1; m_tmr = DRV - 1; end
            if (cfg_load) begin m_id = cfg_user_id; m_pw = cfg_user_pw; m_adm = cfg_admin; end
        end
    end

    // Every-clock comparison of all outputs against the model.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R2", "motor_fwd", motor_fwd, m_phase == 1);
            chk("R3", "lock_open", lock_open, m_phase == 2);
            chk("R3", "motor_rev", motor_rev, m_phase == 3);
            chk("R1", "beep", beep, m_beep > 0);
            chk("R5", "blocked", blocked, m_fails == MAXF);
            chk("R10", "code_changed_pulse", code_changed_pulse, m_chgp);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic press(int c);
        key_valid = 1'b1; key_code = 4'(c);
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic type_code(logic [39:0] v, int n);
        for (int i = 0; i < n; i++) press(int'(v[4*(n-1-i) +: 4]));
        press(10);
    endtask

    task automatic user_try(logic [15:0] id, logic [15:0] pw);
        type_code({24'd0, id}, 4);
        type_code({24'd0, pw}, 4);
    endtask

    localparam int DOOR = 2 * DRV + HLD + 2;

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        chk("R11", "reset motor_fwd", motor_fwd, 1'b0);
        chk("R11", "reset blocked", blocked, 1'b0);
        chk("R11", "reset beep", beep, 1'b0);
        rst_n = 1'b1;
        cfg_load = 1'b1; @(negedge clk); cfg_load = 1'b0;

        // R2 correct unlock, R3 sequence, R1 keys ignored during door
        user_try(16'h1234, 16'h5678);
        chk("R2", "open after final confirm", motor_fwd, 1'b1);
        idle(DRV + 2);
        press(1);
        chk("R1", "no beep during door cycle", beep, 1'b0);
        idle(DOOR);
        press(15);
        chk("R1", "no beep for code 15", beep, 1'b0);

        // R4 wrong password, R8 clear, R9 overflow, R4 wrong id -> R5 block
        user_try(16'h1234, 16'h0000);
        chk("R4", "wrong password stays shut", motor_fwd, 1'b0);
        press(1); press(2); press(11);
        user_try(16'h4321, 16'h5678);
        chk("R4", "reversed digit order refused", motor_fwd, 1'b0);
        for (int i = 0; i < 11; i++) press(i % 10);
        chk("R9", "overflow is third failure", blocked, 1'b1);
        user_try(16'h1234, 16'h5678);
        chk("R5", "blocked ignores user code", motor_fwd, 1'b0);
        chk("R5", "still blocked", blocked, 1'b1);
        idle(2);

        // R6 admin recovery
        type_code(40'h9876543210, 10);
        chk("R6", "admin opens", motor_fwd, 1'b1);
        chk("R6", "admin unblocks", blocked, 1'b0);
        idle(DOOR);

        // R7 success resets consecutive count; R8 clear counts nothing
        user_try(16'h1234, 16'h1111);
        user_try(16'h1234, 16'h1111);
        press(5); press(11);
        user_try(16'h1234, 16'h5678);
        idle(DOOR);
        user_try(16'h1234, 16'h1111);
        user_try(16'h1234, 16'h1111);
        chk("R7", "count restarted after success", blocked, 1'b0);
        chk("R8", "clear added no failure", blocked, 1'b0);
        user_try(16'h1234, 16'h5678);
        idle(DOOR);

        // R10 code change
        press(12);
        user_try(16'h1234, 16'h5678);
        chk("R10", "verified change opens nothing", motor_fwd, 1'b0);
        type_code({24'd0, 16'h4321}, 4);
        chk("R10", "change pulse", code_changed_pulse, 1'b1);
        user_try(16'h1234, 16'h5678);
        chk("R10", "old password refused", motor_fwd, 1'b0);
        user_try(16'h1234, 16'h4321);
        chk("R10", "new password opens", motor_fwd, 1'b1);
        idle(DOOR);
        press(12);
        user_try(16'h1234, 16'h4321);
        type_code({24'd0, 16'h0012}, 2);
        chk("R10", "short new code dropped", code_changed_pulse, 1'b0);

        // R11 host reload
        cfg_user_pw = 16'h2468;
        cfg_load = 1'b1; @(negedge clk); cfg_load = 1'b0;
        user_try(16'h1234, 16'h2468);
        chk("R11", "loaded password opens", motor_fwd, 1'b1);
        idle(DOOR);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule